// File: doc/BRIEF.md
# Two-Word Funnel Shifter

The block shifts a destination word left or right by a count. The bit positions that open up are filled from a second source word rather than with zeros. A value wider than one register can therefore be moved across a register pair, one word at a time. The source is only read. The block returns the new destination word together with five condition flags, and an error bit for counts that have no meaning.

A width select chooses between a 16-bit and a 32-bit operation. The count comes in on an 8-bit port, and only its low five bits are used. A count of zero is a no-op: the destination passes through unchanged and the incoming flags are handed back as they came. All outputs are registered, so each result appears one clock after its operands are presented. A result can be issued every cycle.

Top module: `fsh_dbl_shift`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_q`, `flags_q` and `err_q` are cleared to zero.
- R2: A 32-bit left shift by n (1..31) gives `res_q = (dst << n) | (src >> (32-n))`, truncated to 32 bits.
- R3: A right shift by n gives `res_q = (dst >> n) | (src << (W-n))` truncated to W bits, where W is the active width.
- R4: In 16-bit mode (`wide_i` = 0) only bits [15:0] of `dst_i` and `src_i` take part, and `res_q[31:16]` is always zero.
- R5: The carry flag (`flags_q[0]`) holds the last destination bit shifted out. That is `dst[W-n]` for a left shift and `dst[n-1]` for a right shift, so a 16-bit shift by 16 yields `dst[0]` (left) or `dst[15]` (right).
- R6: For a nonzero in-range count, the sign flag (`flags_q[4]`) is the top bit of the W-bit result. The zero flag (`flags_q[3]`) is set when the result is zero. The auxiliary flag (`flags_q[2]`) is cleared. The parity flag (`flags_q[1]`) is set when `res_q[7:0]` holds an even number of ones.
- R7: Only `cnt_i[4:0]` is used; bits [7:5] have no effect on any output.
- R8: A masked count of zero gives `res_q` = `dst_i` (in 16-bit mode, `dst_i[15:0]` zero-extended), `flags_q` = `flags_i`, and `err_q` = 0.
- R9: In 16-bit mode, a masked count of 17..31 gives `res_q` = 0, `flags_q` = 0 and `err_q` = 1. In every other case `err_q` is 0.
- R10: Each result appears on the outputs at the first rising clock edge after its operands, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dst_i | input | 32 | Destination word |
| src_i | input | 32 | Fill-source word (read only) |
| cnt_i | input | 8 | Shift count; low five bits used |
| dir_right_i | input | 1 | 1 = shift right, 0 = shift left |
| wide_i | input | 1 | 1 = 32-bit operation, 0 = 16-bit |
| flags_i | input | 5 | Incoming flags {sign, zero, aux, parity, carry}, returned on a zero count |
| res_q | output | 32 | New destination value |
| flags_q | output | 5 | {sign, zero, aux, parity, carry} |
| err_q | output | 1 | Undefined-count indicator |

## Verification
The block holds no state beyond its output register. A wrong shift amount, a wrong fill direction or a wrong width slice therefore shows up in `res_q` one clock after the operands that caused it, and the error does not carry over into later results. A carry taken from the wrong bit position stays hidden unless the destination bits around position n differ. For that reason the data patterns include alternating and single-bit words, and the sweep covers every count in both directions and both widths. Count bits above bit 4 are driven at random, so any leak from them into a result or flag shows as a mismatch within one cycle.

// File: rtl/fsh_pkg.sv
// Shared definitions for the two-word funnel shifter.
// Assumes the flag vector order {sign, zero, aux, parity, carry}, MSB first.
package fsh_pkg;

    typedef struct packed {
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } fsh_flags_t;

endpackage

// File: rtl/fsh_cnt_dec.sv
// Count decoder: masks the raw count to its low CW bits, flags a zero
// count and flags a count that is undefined for the half-width mode.
// Assumes DW is a power of two and CNT_IN_W >= CW.
module fsh_cnt_dec #(
    parameter int DW       = 32,
    parameter int CNT_IN_W = 8,
    parameter int CW       = $clog2(DW)
) (
    input  logic [CNT_IN_W-1:0] cnt_raw,
    input  logic                wide,
    output logic [CW-1:0]       amt,
    output logic                is_zero,
    output logic                over_range
);
    localparam int HW = DW / 2;

    // Mask the count and classify it.
    always_comb begin
        amt        = cnt_raw[CW-1:0];
        is_zero    = (amt == '0);
        over_range = !wide && (int'(amt) > HW);
    end
endmodule

// File: rtl/fsh_funnel_core.sv
// Funnel shift of one operand width W. A left shift fills the low end from
// the high bits of src; a right shift fills the high end from the low bits
// of src. cout is the last dst bit pushed out.
// Assumes 1 <= amt <= W whenever the outputs are used; other values give
// don't-care outputs that the caller discards.
module fsh_funnel_core #(
    parameter int W  = 32,
    parameter int CW = 5
) (
    input  logic [W-1:0]  dst,
    input  logic [W-1:0]  src,
    input  logic [CW-1:0] amt,
    input  logic          go_right,
    output logic [W-1:0]  res,
    output logic          cout
);
    int unsigned n;
    int unsigned back;

    // Form the shifted word and select the last bit that leaves dst.
    always_comb begin
        n    = int'(amt);
        back = (n <= W) ? (W - n) : 0;
        if (go_right) begin
            res  = (dst >> n) | (src << back);
            cout = (n >= 1 && n <= W) ? dst[n - 1] : 1'b0;
        end else begin
            res  = (dst << n) | (src >> back);
            cout = (n >= 1 && n <= W) ? dst[W - n] : 1'b0;
        end
    end
endmodule

// File: rtl/fsh_flag_gen.sv
// Flag generator for a shift that has taken place: sign from the top bit
// of the active width, zero over the zero-extended result, even parity of
// the low byte, aux cleared, carry passed through.
// Assumes res is already zero-extended above the active width.
module fsh_flag_gen
    import fsh_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] res,
    input  logic          wide,
    input  logic          cin,
    output fsh_flags_t    flg
);
    localparam int HW = DW / 2;

    // Derive each flag from the shifted word.
    always_comb begin
        flg.sgn = wide ? res[DW-1] : res[HW-1];
        flg.zro = (res == '0);
        flg.aux = 1'b0;
        flg.par = ~^res[7:0];
        flg.cry = cin;
    end
endmodule

// File: rtl/fsh_dbl_shift.sv
// Two-word funnel shifter top. Builds one funnel core per supported width,
// selects by the width input, applies zero-count and undefined-count rules
// and registers the result, the flags and the error bit.
// Assumes DW is even, a power of two and at least 16.
module fsh_dbl_shift
    import fsh_pkg::*;
#(
    parameter int DW       = 32,
    parameter int CNT_IN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       dst_i,
    input  logic [DW-1:0]       src_i,
    input  logic [CNT_IN_W-1:0] cnt_i,
    input  logic                dir_right_i,
    input  logic                wide_i,
    input  logic [4:0]          flags_i,
    output logic [DW-1:0]       res_q,
    output logic [4:0]          flags_q,
    output logic                err_q
);
    localparam int HW = DW / 2;
    localparam int CW = $clog2(DW);
    localparam int NV = 2;

    logic [CW-1:0] amt;
    logic          cnt_zero;
    logic          cnt_over;
    logic [DW-1:0] core_res [NV];
    logic          core_cry [NV];
    logic [DW-1:0] sel_res;
    logic          sel_cry;
    fsh_flags_t    gen_flg;
    logic [DW-1:0] nxt_res;
    logic [4:0]    nxt_flg;
    logic          nxt_err;

    fsh_cnt_dec #(.DW(DW), .CNT_IN_W(CNT_IN_W), .CW(CW)) u_cnt (
        .cnt_raw    (cnt_i),
        .wide       (wide_i),
        .amt        (amt),
        .is_zero    (cnt_zero),
        .over_range (cnt_over)
    );

    // One funnel core per width variant; index 0 is half width, 1 full width.
    for (genvar g = 0; g < NV; g++) begin : g_core
        localparam int W = (g == 0) ? HW : DW;
        logic [W-1:0] r;
        logic         c;
        fsh_funnel_core #(.W(W), .CW(CW)) u_core (
            .dst      (dst_i[W-1:0]),
            .src      (src_i[W-1:0]),
            .amt      (amt),
            .go_right (dir_right_i),
            .res      (r),
            .cout     (c)
        );
        assign core_res[g] = DW'(r);
        assign core_cry[g] = c;
    end

    // Pick the core matching the selected width.
    always_comb begin
        sel_res = core_res[wide_i ? 1 : 0];
        sel_cry = core_cry[wide_i ? 1 : 0];
    end

    fsh_flag_gen #(.DW(DW)) u_flg (
        .res  (sel_res),
        .wide (wide_i),
        .cin  (sel_cry),
        .flg  (gen_flg)
    );

    // Apply the undefined-count and zero-count rules ahead of the register.
    always_comb begin
        nxt_err = 1'b0;
        if (cnt_over) begin
            nxt_res = '0;
            nxt_flg = '0;
            nxt_err = 1'b1;
        end else if (cnt_zero) begin
            nxt_res = wide_i ? dst_i : DW'(dst_i[HW-1:0]);
            nxt_flg = flags_i;
        end else begin
            nxt_res = sel_res;
            nxt_flg = gen_flg;
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
            err_q   <= 1'b0;
        end else begin
            res_q   <= nxt_res;
            flags_q <= nxt_flg;
            err_q   <= nxt_err;
        end
    end

    // R9
    err_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (res_q == '0 && flags_q == '0));

    // R4
    half_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wide_i)) |-> (res_q[DW-1:HW] == '0));

    // R8
    zero_count_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_i[CW-1:0]) == '0) |->
        (flags_q == $past(flags_i) && !err_q));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cnt_i[CW-1:0]) != '0 && !err_q) |->
        (flags_q[3] == (res_q == '0) && !flags_q[2]));

    // R9
    err_only_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wide_i)) |-> !err_q);

endmodule

// File: tb/fsh_dbl_shift_bench.sv
`timescale 1ns/1ps
module fsh_dbl_shift_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] dst_i, src_i;
    logic [7:0]  cnt_i;
    logic        dir_right_i, wide_i;
    logic [4:0]  flags_i;
    logic [31:0] res_q;
    logic [4:0]  flags_q;
    logic        err_q;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fsh_dbl_shift u_fsh_dbl_shift (
        .clk(clk), .rst_n(rst_n), .dst_i(dst_i), .src_i(src_i), .cnt_i(cnt_i),
        .dir_right_i(dir_right_i), .wide_i(wide_i), .flags_i(flags_i),
        .res_q(res_q), .flags_q(flags_q), .err_q(err_q)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: shift one bit at a time.
    task automatic model(input logic [31:0] d0, input logic [31:0] s0, input int n,
                         input bit right, input bit wide, input logic [4:0] fin,
                         output logic [31:0] r, output logic [4:0] f, output logic e);
        int w = wide ? 32 : 16;
        logic [31:0] m = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        logic [31:0] d = d0 & m;
        logic [31:0] s = s0 & m;
        logic c = 1'b0;
        int ones = 0;
        e = 1'b0;
        if (!wide && n > 16) begin
            r = 0; f = 0; e = 1'b1;
        end else if (n == 0) begin
            r = d; f = fin;
        end else begin
            for (int i = 0; i < n; i++) begin
                if (right) begin
                    c = d[0];
                    d = (d >> 1) | ({31'd0, s[0]} << (w - 1));
                    s = s >> 1;
                end else begin
                    c = d[w-1];
                    d = ((d << 1) | {31'd0, s[w-1]}) & m;
                    s = (s << 1) & m;
                end
            end
            r = d;
            for (int b = 0; b < 8; b++) ones += int'(d[b]);
            f = {d[w-1], (d == 0), 1'b0, (ones % 2 == 0), c};
        end
    endtask

    logic [31:0] lfsr = 32'hACE1_1357;
    function automatic logic [31:0] nxt(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        logic [31:0] er, pd, ps;
        logic [4:0]  ef;
        logic        ee;
        string       tag;
        rst_n = 1'b0; dst_i = 32'hFFFF_FFFF; src_i = 32'h1234_5678;
        cnt_i = 8'd3; dir_right_i = 1'b0; wide_i = 1'b1; flags_i = 5'h1F;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 res", res_q, 0);
        chk("R1 flags", {27'd0, flags_q}, 0);
        chk("R1 err", {31'd0, err_q}, 0);
        rst_n = 1'b1;
        // R10: no change before the edge, result after one edge
        #1;
        chk("R10 before edge", res_q, 0);
        @(negedge clk);
        chk("R10 after edge", res_q, 32'hFFFF_FFF8 | 32'h0);
        for (int p = 0; p < 24; p++) begin
            case (p)
                0: begin pd = 32'hFFFF_FFFF; ps = 32'h0; end
                1: begin pd = 32'h0; ps = 32'hFFFF_FFFF; end
                2: begin pd = 32'hAAAA_5555; ps = 32'h5555_AAAA; end
                3: begin pd = 32'h8000_8001; ps = 32'h0001_8000; end
                4: begin pd = 32'h0; ps = 32'h0; end
                default: begin
                    lfsr = nxt(lfsr); pd = lfsr;
                    lfsr = nxt(lfsr); ps = lfsr;
                end
            endcase
            for (int wd = 0; wd < 2; wd++)
                for (int dr = 0; dr < 2; dr++)
                    for (int n = 0; n < 32; n++) begin
                        lfsr = nxt(lfsr);
                        @(negedge clk);
                        dst_i = pd; src_i = ps; wide_i = wd[0]; dir_right_i = dr[0];
                        cnt_i = {lfsr[7:5], n[4:0]};
                        flags_i = lfsr[12:8];
                        model(pd, ps, n, dr[0], wd[0], lfsr[12:8], er, ef, ee);
                        if (wd == 0 && n > 16) tag = "R9";
                        else if (n == 0) tag = "R8";
                        else if (wd == 0) tag = dr ? "R4 R3" : "R4";
                        else tag = dr ? "R3" : "R2";
                        if (lfsr[7:5] != 0) tag = {tag, " R7"};
                        @(negedge clk);
                        chk({tag, " res"}, res_q, er);
                        chk({tag, " R5 carry"}, {31'd0, flags_q[0]}, {31'd0, ef[0]});
                        chk({tag, " R6 flags"}, {27'd0, flags_q}, {27'd0, ef});
                        chk({tag, " R9 err"}, {31'd0, err_q}, {31'd0, ee});
                    end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule